// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges reset requests from six causes into a single internal reset for the core and memories. The six causes are power-on, low-voltage detect, watchdog overflow, illegal opcode fetch, illegal address access and a low level on the external reset pad. Every accepted request starts a recovery sequence. The sequence length is fixed per cause and is counted in oscillator clock cycles.

Power-on and low-voltage requests begin with a stabilisation phase. In that phase the core and peripheral clocks are gated off while the oscillator settles. All recoveries then pass through three phases:

- a pad-drive phase, in which the reset pad pull-down is active;
- an internal hold phase;
- a short release phase.

The cause of each request is latched in a six-bit status register. Software reads that register, and a read strobe clears it. A request that arrives during a recovery restarts the sequence, and the restarted sequence takes the longer of the two lengths.

The pad input is asynchronous and passes through a two-flop synchroniser. The block drives that same pad low itself, so the pad input is masked while its own pull-down is active and for the synchroniser depth after it. This keeps the block from retriggering on its own drive.

Top module: `reset_sequencer`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `core_rst` is 0, `pad_pull` is 0, `clk_en` is 1 and `cause` is 0.
- R2: A power-on or low-voltage request holds `clk_en` at 0 for exactly 4096 cycles, starting in the cycle after the request is sampled.
- R3: A power-on or low-voltage request holds `core_rst` at 1 for exactly 4163 cycles (4096 + 32 + 32 + 3).
- R4: A watchdog, illegal-opcode, illegal-address or pad request holds `core_rst` at 1 for exactly 67 cycles and leaves `clk_en` at 1 throughout.
- R5: `pad_pull` is 1 during the stabilisation phase and during the 32 cycles that follow it. It is 0 for the last 35 cycles of every recovery, and never 1 while `core_rst` is 0.
- R6: A request sampled high at a rising clock edge makes `core_rst` 1 right after that edge.
- R7: A power-on request leaves `cause` equal to 6'b000001. Bit 0 is the power-on bit, and all other bits are cleared.
- R8: A watchdog overflow (`wdg_ovf`) starts a recovery and sets cause bit 2 only while `wdg_off` is 0. With `wdg_off` at 1 it has no effect on `core_rst` or on `cause`.
- R9: A one-cycle `stat_rd` clears all cause bits in the next cycle. A cause set in the same cycle as the read survives it.
- R10: A one-cycle low level on `pad_n_i`, seen in the clock edge after it is driven, raises `core_rst` two edges later (synchroniser delay) and sets cause bit 5. The block's own pad drive does not retrigger a recovery.
- R11: A request during a recovery restarts the count. The new length is the long one if either the running or the new request is long. Otherwise it is the short one.
- R12: Each cause sets its own bit, and earlier bits are kept: bit 1 low voltage, bit 2 watchdog, bit 3 illegal opcode, bit 4 illegal address, bit 5 pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low hard reset of the sequencer's flops |
| por_evt | input | 1 | Power-on detected pulse, synchronous |
| lvd_evt | input | 1 | Low-voltage detected pulse, synchronous |
| wdg_ovf | input | 1 | Watchdog overflow pulse, synchronous |
| wdg_off | input | 1 | Watchdog disable configuration bit |
| bad_opc | input | 1 | Illegal opcode pulse, synchronous |
| bad_adr | input | 1 | Illegal address pulse, synchronous |
| pad_n_i | input | 1 | Reset pad level as received, asynchronous, active low |
| stat_rd | input | 1 | Status read strobe; clears cause bits |
| core_rst | output | 1 | Internal reset to core and memories |
| pad_pull | output | 1 | Pull-down enable for the reset pad |
| clk_en | output | 1 | Core and peripheral clock enable |
| cause | output | 6 | Latched reset cause bits |

## Verification
The assertions assume that every request input except `pad_n_i` is synchronous to `clk`. They also assume that `pad_n_i` reflects the wired-AND of the outside driver and the block's own `pad_pull`, so the mask on the pad path is exercised. The bench meets these assumptions: it drives all pulses on falling edges and builds `pad_n_i` from its external-low flag combined with the design's `pad_pull`. The reference model covers restarts at several points inside both the long and the short sequence, a read that coincides with a new cause, and a masked watchdog overflow while the sequencer is idle.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_STAB = 3'd1,
    ST_PAD  = 3'd2,
    ST_HOLD = 3'd3,
    ST_REL  = 3'd4
  } seq_state_e;

  localparam int NUM_CAUSE = 6;
  localparam int CZ_POR = 0;
  localparam int CZ_LVD = 1;
  localparam int CZ_WDG = 2;
  localparam int CZ_OPC = 3;
  localparam int CZ_ADR = 4;
  localparam int CZ_PAD = 5;

endpackage

// File: rtl/rstseq_pad_sync.sv
module rstseq_pad_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_n_i,
  input  logic pull_now,
  output logic pad_req
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] pull_hist_q;
  logic              masked;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            sync_q[g]      <= 1'b1;
            pull_hist_q[g] <= 1'b0;
          end else begin
            sync_q[g]      <= pad_n_i;
            pull_hist_q[g] <= pull_now;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            sync_q[g]      <= 1'b1;
            pull_hist_q[g] <= 1'b0;
          end else begin
            sync_q[g]      <= sync_q[g-1];
            pull_hist_q[g] <= pull_hist_q[g-1];
          end
        end
      end
    end
  endgenerate

  always_comb begin
    masked  = pull_now | (|pull_hist_q);
    pad_req = ~sync_q[STAGES-1] & ~masked;
  end

endmodule

// File: rtl/rstseq_req_merge.sv
module rstseq_req_merge
  import rstseq_pkg::*;
(
  input  logic                 por_evt,
  input  logic                 lvd_evt,
  input  logic                 wdg_ovf,
  input  logic                 wdg_off,
  input  logic                 bad_opc,
  input  logic                 bad_adr,
  input  logic                 pad_req,
  output logic                 req_any,
  output logic                 req_long,
  output logic [NUM_CAUSE-1:0] new_cause
);

  always_comb begin
    new_cause         = '0;
    new_cause[CZ_POR] = por_evt;
    new_cause[CZ_LVD] = lvd_evt;
    new_cause[CZ_WDG] = wdg_ovf & ~wdg_off;
    new_cause[CZ_OPC] = bad_opc;
    new_cause[CZ_ADR] = bad_adr;
    new_cause[CZ_PAD] = pad_req;
    req_any           = |new_cause;
    req_long          = new_cause[CZ_POR] | new_cause[CZ_LVD];
  end

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int STAB_CYC = 4096,
  parameter int PAD_CYC  = 32,
  parameter int HOLD_CYC = 32,
  parameter int REL_CYC  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_any,
  input  logic req_long,
  output logic core_rst,
  output logic pad_pull,
  output logic clk_en
);

  localparam int MAX_AB  = (STAB_CYC > PAD_CYC) ? STAB_CYC : PAD_CYC;
  localparam int MAX_CD  = (HOLD_CYC > REL_CYC) ? HOLD_CYC : REL_CYC;
  localparam int MAX_LEN = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  localparam logic [CNT_W-1:0] STAB_LAST = CNT_W'(STAB_CYC - 1);
  localparam logic [CNT_W-1:0] PAD_LAST  = CNT_W'(PAD_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] REL_LAST  = CNT_W'(REL_CYC - 1);

  seq_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             long_q, long_n;
  logic             busy;
  logic             cnt_en;

  assign busy = (state_q != ST_IDLE);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q + CNT_W'(1);
    long_n  = long_q;
    if (req_any) begin
      long_n  = req_long | (busy & long_q);
      state_n = long_n ? ST_STAB : ST_PAD;
      cnt_n   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_n  = '0;
          long_n = 1'b0;
        end
        ST_STAB: if (cnt_q == STAB_LAST) begin
          state_n = ST_PAD;
          cnt_n   = '0;
        end
        ST_PAD: if (cnt_q == PAD_LAST) begin
          state_n = ST_HOLD;
          cnt_n   = '0;
        end
        ST_HOLD: if (cnt_q == HOLD_LAST) begin
          state_n = ST_REL;
          cnt_n   = '0;
        end
        ST_REL: if (cnt_q == REL_LAST) begin
          state_n = ST_IDLE;
          cnt_n   = '0;
          long_n  = 1'b0;
        end
        default: begin
          state_n = ST_IDLE;
          cnt_n   = '0;
          long_n  = 1'b0;
        end
      endcase
    end
  end

  assign cnt_en = req_any | busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      long_q  <= 1'b0;
    end else if (cnt_en) begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      long_q  <= long_n;
    end
  end

  always_comb begin
    core_rst = busy;
    pad_pull = (state_q == ST_STAB) | (state_q == ST_PAD);
    clk_en   = (state_q != ST_STAB);
  end

endmodule

// File: rtl/rstseq_cause_reg.sv
module rstseq_cause_reg
  import rstseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CAUSE-1:0] new_cause,
  input  logic                 stat_rd,
  output logic [NUM_CAUSE-1:0] cause
);

  logic [NUM_CAUSE-1:0] cause_q, cause_n;
  logic                 upd_en;

  assign upd_en = stat_rd | (|new_cause);

  always_comb begin
    if (new_cause[CZ_POR]) begin
      cause_n         = '0;
      cause_n[CZ_POR] = 1'b1;
    end else begin
      cause_n = (stat_rd ? '0 : cause_q) | new_cause;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (upd_en) begin
      cause_q <= cause_n;
    end
  end

  assign cause = cause_q;

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int STAB_CYC    = 4096,
  parameter int PAD_CYC     = 32,
  parameter int HOLD_CYC    = 32,
  parameter int REL_CYC     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_evt,
  input  logic       lvd_evt,
  input  logic       wdg_ovf,
  input  logic       wdg_off,
  input  logic       bad_opc,
  input  logic       bad_adr,
  input  logic       pad_n_i,
  input  logic       stat_rd,
  output logic       core_rst,
  output logic       pad_pull,
  output logic       clk_en,
  output logic [5:0] cause
);

  logic                 pad_req;
  logic                 req_any;
  logic                 req_long;
  logic [NUM_CAUSE-1:0] new_cause;

  rstseq_pad_sync #(.STAGES(SYNC_STAGES)) u_pad_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_n_i  (pad_n_i),
    .pull_now (pad_pull),
    .pad_req  (pad_req)
  );

  rstseq_req_merge u_req_merge (
    .por_evt   (por_evt),
    .lvd_evt   (lvd_evt),
    .wdg_ovf   (wdg_ovf),
    .wdg_off   (wdg_off),
    .bad_opc   (bad_opc),
    .bad_adr   (bad_adr),
    .pad_req   (pad_req),
    .req_any   (req_any),
    .req_long  (req_long),
    .new_cause (new_cause)
  );

  rstseq_fsm #(
    .STAB_CYC (STAB_CYC),
    .PAD_CYC  (PAD_CYC),
    .HOLD_CYC (HOLD_CYC),
    .REL_CYC  (REL_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_any  (req_any),
    .req_long (req_long),
    .core_rst (core_rst),
    .pad_pull (pad_pull),
    .clk_en   (clk_en)
  );

  rstseq_cause_reg u_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .new_cause (new_cause),
    .stat_rd   (stat_rd),
    .cause     (cause)
  );

endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       por_evt,
  input logic       lvd_evt,
  input logic       wdg_ovf,
  input logic       wdg_off,
  input logic       bad_opc,
  input logic       bad_adr,
  input logic       stat_rd,
  input logic       pad_req,
  input logic       req_any,
  input logic       core_rst,
  input logic       pad_pull,
  input logic       clk_en,
  input logic [5:0] cause
);

  AST_PULL_INSIDE_RST: assert property (@(posedge clk) disable iff (!rst_n)
    pad_pull |-> core_rst); // R5

  AST_GATE_INSIDE_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> pad_pull); // R2

  AST_REQ_RAISES_RST: assert property (@(posedge clk) disable iff (!rst_n)
    req_any |=> core_rst); // R6

  AST_POR_ONLY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> (cause == 6'b000001)); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !req_any) |=> (cause == 6'b000000)); // R9

  AST_WDG_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wdg_ovf && wdg_off && !por_evt && !lvd_evt && !bad_opc && !bad_adr
     && !pad_req && !core_rst) |=> !core_rst); // R8

  AST_GATE_ENDS_IN_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> pad_pull); // R5

endmodule

bind reset_sequencer rstseq_checker u_rstseq_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .por_evt  (por_evt),
  .lvd_evt  (lvd_evt),
  .wdg_ovf  (wdg_ovf),
  .wdg_off  (wdg_off),
  .bad_opc  (bad_opc),
  .bad_adr  (bad_adr),
  .stat_rd  (stat_rd),
  .pad_req  (pad_req),
  .req_any  (req_any),
  .core_rst (core_rst),
  .pad_pull (pad_pull),
  .clk_en   (clk_en),
  .cause    (cause)
);

// File: tb/test_reset_sequencer.sv
`timescale 1ns/1ps
module test_reset_sequencer;

  localparam int LONG_LEN  = 4163;
  localparam int SHORT_LEN = 67;
  localparam int PULL_OFF  = 35;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_evt = 0, lvd_evt = 0, wdg_ovf = 0, wdg_off = 0;
  logic bad_opc = 0, bad_adr = 0, stat_rd = 0, ext_low = 0;
  logic pad_n_i;
  logic core_rst, pad_pull, clk_en;
  logic [5:0] cause;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign pad_n_i = ~(ext_low | pad_pull);

  reset_sequencer i_reset_sequencer (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .lvd_evt(lvd_evt),
    .wdg_ovf(wdg_ovf), .wdg_off(wdg_off), .bad_opc(bad_opc),
    .bad_adr(bad_adr), .pad_n_i(pad_n_i), .stat_rd(stat_rd),
    .core_rst(core_rst), .pad_pull(pad_pull), .clk_en(clk_en), .cause(cause)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int   m_rem;
  bit   m_long;
  int   m_cause;
  bit   s1, s2, pd1, pd2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem = 0; m_long = 0; m_cause = 0;
      s1 = 1; s2 = 1; pd1 = 0; pd2 = 0;
    end else begin
      bit pull_cur, pad, preq, any, lng;
      int newc;
      pull_cur = (m_rem > PULL_OFF);
      pad      = !(ext_low || pull_cur);
      preq     = !s2 && !(pull_cur || pd1 || pd2);
      newc = (por_evt ? 1 : 0) | (lvd_evt ? 2 : 0) | ((wdg_ovf && !wdg_off) ? 4 : 0)
           | (bad_opc ? 8 : 0) | (bad_adr ? 16 : 0) | (preq ? 32 : 0);
      any = (newc != 0);
      lng = por_evt || lvd_evt;
      if (any) begin
        m_long = lng || (m_rem > 0 && m_long);
        m_rem  = m_long ? LONG_LEN : SHORT_LEN;
      end else if (m_rem > 0) begin
        m_rem--;
      end
      if (por_evt) m_cause = 1;
      else m_cause = (stat_rd ? 0 : m_cause) | newc;
      s2 = s1; s1 = pad; pd2 = pd1; pd1 = pull_cur;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_rst, e_pull, e_en;
      e_rst  = (m_rem > 0);
      e_pull = (m_rem > PULL_OFF);
      e_en   = !(m_long && m_rem > SHORT_LEN);
      chk(core_rst == e_rst, "R3 model core_rst", core_rst, e_rst);
      chk(pad_pull == e_pull, "R5 model pad_pull", pad_pull, e_pull);
      chk(clk_en == e_en, "R2 model clk_en", clk_en, e_en);
      chk(cause == m_cause[5:0], "R12 model cause", cause, m_cause);
    end
  end

  int n_rst, n_pull, n_gate;

  task automatic measure();
    n_rst = 0; n_pull = 0; n_gate = 0;
    while (core_rst && n_rst < 10000) begin
      n_rst++;
      if (pad_pull) n_pull++;
      if (!clk_en) n_gate++;
      @(negedge clk);
    end
  endtask

  task automatic fire(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(core_rst == 0 && pad_pull == 0 && clk_en == 1, "R1 idle outputs",
        {core_rst, pad_pull, clk_en}, 3'b001);
    chk(cause == 0, "R1 cause cleared", cause, 0);

    // power-on: long sequence
    fire(por_evt);
    chk(core_rst == 1, "R6 rst after request", core_rst, 1);
    measure();
    chk(n_rst == LONG_LEN, "R3 long reset length", n_rst, LONG_LEN);
    chk(n_gate == 4096, "R2 clock gate length", n_gate, 4096);
    chk(n_pull == 4128, "R5 pull length long", n_pull, 4128);
    chk(cause == 1, "R7 por cause", cause, 1);

    // illegal opcode: short sequence
    fire(bad_opc);
    measure();
    chk(n_rst == SHORT_LEN, "R4 short reset length", n_rst, SHORT_LEN);
    chk(n_pull == 32, "R5 pull length short", n_pull, 32);
    chk(n_gate == 0, "R4 no clock gate", n_gate, 0);
    chk(cause == 9, "R12 opcode bit kept with por", cause, 9);

    // read clears
    fire(stat_rd);
    chk(cause == 0, "R9 read clears", cause, 0);

    // watchdog masked
    wdg_off = 1'b1;
    fire(wdg_ovf);
    repeat (3) begin
      chk(core_rst == 0, "R8 masked wdg no reset", core_rst, 0);
      @(negedge clk);
    end
    chk(cause == 0, "R8 masked wdg no cause", cause, 0);
    wdg_off = 1'b0;
    fire(wdg_ovf);
    measure();
    chk(n_rst == SHORT_LEN, "R8 wdg short length", n_rst, SHORT_LEN);
    chk(cause == 4, "R8 wdg cause bit", cause, 4);

    // read and new cause together
    @(negedge clk); stat_rd = 1; bad_adr = 1;
    @(negedge clk); stat_rd = 0; bad_adr = 0;
    chk(cause == 16, "R9 set wins over read", cause, 16);
    measure();

    // low voltage
    fire(lvd_evt);
    measure();
    chk(n_rst == LONG_LEN, "R3 lvd long length", n_rst, LONG_LEN);
    chk(cause == 18, "R12 lvd bit kept with adr", cause, 18);

    // por clears others
    fire(por_evt);
    chk(cause == 1, "R7 por clears others", cause, 1);
    measure();

    // external pad
    @(negedge clk); ext_low = 1;
    @(negedge clk); ext_low = 0;
    chk(core_rst == 0, "R10 sync delay 1", core_rst, 0);
    @(negedge clk);
    chk(core_rst == 0, "R10 sync delay 2", core_rst, 0);
    @(negedge clk);
    chk(core_rst == 1, "R10 pad reset raised", core_rst, 1);
    measure();
    chk(n_rst == SHORT_LEN, "R10 pad short length", n_rst, SHORT_LEN);
    chk(cause == 33, "R10 pad cause bit", cause, 33);
    repeat (10) @(negedge clk);
    chk(core_rst == 0, "R10 no self retrigger", core_rst, 0);

    // restarts
    fire(bad_opc);
    repeat (20) @(negedge clk);
    fire(lvd_evt);
    measure();
    chk(n_rst == LONG_LEN, "R11 short then long", n_rst, LONG_LEN);
    fire(lvd_evt);
    repeat (100) @(negedge clk);
    fire(bad_adr);
    measure();
    chk(n_rst == LONG_LEN, "R11 long then short keeps long", n_rst, LONG_LEN);
    fire(bad_opc);
    repeat (40) @(negedge clk);
    fire(bad_adr);
    measure();
    chk(n_rst == SHORT_LEN, "R11 short restart", n_rst, SHORT_LEN);

    repeat (5) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule